// File: doc/BRIEF.md
# PLL Fastlock Window Controller

This block times the wide-bandwidth interval that a fractional-N synthesizer uses to settle faster after a frequency change. Register words arrive already shifted in, as 32-bit values with a load strobe that is synchronous to the phase-detector clock. A write to register 4 that carries the switched-resistor fastlock code arms a down-counter. The counter then runs for a programmed number of phase-detector cycles. While it runs, the block raises a charge-pump boost flag, which asks the analog side for sixteen times the normal current. If the output-multiplexer select (held from register 0) names the fastlock switch, the block also pulls the multiplexed pin to ground. This switches in the extra loop-filter resistor.

When the count runs out, both controls return to normal bandwidth and a one-cycle completion pulse is raised. A level output shows that the window is open. Because the counter is clocked at the phase-detector rate, the time in wide bandwidth equals the timer value divided by that rate. For example, a value of 520 at 13 MHz gives 40 µs.

Top module: `fastlock_ctl`

## Requirements
- R1: After reset, `active_o`, `boost_o`, `sw_close_o` and `done_o` are all 0, and the stored select value is 4'b0000.
- R2: A loaded word addresses a register through bits [2:0]. Only address 4 affects the timer and only address 0 affects the select. Words with any other address change no output.
- R3: A load to address 4 with bits [20:19] = 2'b01 and a timer value N = bits [18:7] greater than 0 sets `active_o` high for exactly N clock cycles. The window starts in the cycle after the load edge.
- R4: `boost_o` is high exactly in the cycles where the window is open.
- R5: `sw_close_o` is high only while the window is open and the latest address-0 write held bits [30:27] = 4'b1100. Otherwise the pin is released (0).
- R6: When a window runs out by counting, `done_o` is high for exactly one cycle: the first cycle after `active_o` falls.
- R7: A valid address-4 load during an open window restarts the count with the new value, and no `done_o` pulse is given for the interrupted window.
- R8: An address-4 load whose mode field is not 2'b01, or whose timer value is 0, closes any open window in the next cycle without a `done_o` pulse.
- R9: An address-0 write during an open window changes `sw_close_o` from the next cycle on, without disturbing the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe for `ld_word` |
| ld_word | input | 32 | Decoded register word, address in [2:0] |
| boost_o | output | 1 | Charge-pump ×16 boost request |
| sw_close_o | output | 1 | 1 = drive the multiplexed pin to ground |
| active_o | output | 1 | Fastlock window open |
| done_o | output | 1 | One-cycle pulse on natural expiry |

## Verification
The bench builds the block with its default 12-bit timer field at bits [18:7] and the 3-bit address field. This puts the full range within reach: the shortest window of one cycle, the 520-cycle example case, and the largest value of 4095, all in one short run. A per-cycle reference model drives a scoreboard that compares all four outputs every cycle. This also covers restarts, aborts, ignored addresses and select changes made in the middle of a window.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int WORD_W   = 32;
  localparam int TIMER_LSB = 7;
  localparam int SEL_LSB  = 27;
  localparam int SEL_W    = 4;
  localparam logic [1:0]       MODE_SWR  = 2'b01;
  localparam logic [SEL_W-1:0] SEL_FLSW  = 4'b1100;
  localparam int REG_SEL_ADDR   = 0;
  localparam int REG_TIMER_ADDR = 4;

  function automatic logic [SEL_W-1:0] word_sel(input logic [WORD_W-1:0] w);
    return w[SEL_LSB +: SEL_W];
  endfunction
endpackage

// File: rtl/fl_regcap.sv
module fl_regcap
  import fl_pkg::*;
#(
  parameter int TIMER_W = 12,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [WORD_W-1:0]  ld_word,
  output logic               wr_timer,
  output logic [TIMER_W-1:0] load_val,
  output logic               sel_is_sw
);
  localparam int MODE_LSB = TIMER_LSB + TIMER_W;

  logic [ADDR_W-1:0]  addr;
  logic [1:0]         mode;
  logic [TIMER_W-1:0] tval;
  logic [SEL_W-1:0]   sel_q;
  logic               wr_sel;

  assign addr     = ld_word[ADDR_W-1:0];
  assign mode     = ld_word[MODE_LSB +: 2];
  assign tval     = ld_word[TIMER_LSB +: TIMER_W];
  assign wr_timer = ld_en && (addr == ADDR_W'(REG_TIMER_ADDR));
  assign wr_sel   = ld_en && (addr == ADDR_W'(REG_SEL_ADDR));
  assign load_val = (mode == MODE_SWR) ? tval : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_sel) sel_q <= word_sel(ld_word);
  end

  assign sel_is_sw = (sel_q == SEL_FLSW);
endmodule

// File: rtl/fl_timer.sv
module fl_timer #(
  parameter int TIMER_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [TIMER_W-1:0] load_val,
  output logic [TIMER_W-1:0] cnt_o,
  output logic               active,
  output logic               done
);
  localparam logic [TIMER_W-1:0] ONE = TIMER_W'(1);

  logic [TIMER_W-1:0] cnt_q;
  logic               done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= !load && (cnt_q == ONE);
      if (load)              cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign active = (cnt_q != '0);
  assign done   = done_q;
endmodule

// File: rtl/fl_outmux.sv
module fl_outmux (
  input  logic active,
  input  logic sel_is_sw,
  output logic boost,
  output logic sw_close
);
  assign boost    = active;
  assign sw_close = active && sel_is_sw;
endmodule

// File: rtl/fastlock_ctl.sv
module fastlock_ctl #(
  parameter int TIMER_W = 12,
  parameter int ADDR_W  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_en,
  input  logic [31:0] ld_word,
  output logic        boost_o,
  output logic        sw_close_o,
  output logic        active_o,
  output logic        done_o
);
  logic               wr_timer_w;
  logic [TIMER_W-1:0] load_val_w;
  logic               sel_is_sw_w;
  logic [TIMER_W-1:0] cnt_w;
  logic               active_w;
  logic               done_w;

  fl_regcap #(.TIMER_W(TIMER_W), .ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_word(ld_word),
    .wr_timer(wr_timer_w), .load_val(load_val_w), .sel_is_sw(sel_is_sw_w)
  );

  fl_timer #(.TIMER_W(TIMER_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(wr_timer_w), .load_val(load_val_w),
    .cnt_o(cnt_w), .active(active_w), .done(done_w)
  );

  fl_outmux u_mux (
    .active(active_w), .sel_is_sw(sel_is_sw_w),
    .boost(boost_o), .sw_close(sw_close_o)
  );

  assign active_o = active_w;
  assign done_o   = done_w;
endmodule

// File: rtl/fl_chk.sv
module fl_chk #(
  parameter int TIMER_W = 12,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ld_en,
  input logic [31:0]        ld_word,
  input logic               wr_timer,
  input logic [TIMER_W-1:0] cnt,
  input logic               active,
  input logic               boost,
  input logic               sw_close,
  input logic               done
);
  localparam int MODE_LSB = 7 + TIMER_W;

  logic good_load;
  logic bad_load;
  assign good_load = ld_en && (ld_word[ADDR_W-1:0] == ADDR_W'(4)) &&
                     (ld_word[MODE_LSB +: 2] == 2'b01) && (ld_word[7 +: TIMER_W] != '0);
  assign bad_load  = ld_en && (ld_word[ADDR_W-1:0] == ADDR_W'(4)) && !good_load;

  // R3
  load_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_load |=> active);
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wr_timer) |=> (cnt == TIMER_W'($past(cnt) - 1'b1)));
  // R8
  abort_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_load |=> (!active && !done));
  // R6
  done_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!active && $past(active)));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  switch_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_close |-> (boost && active));
  // R4
  boost_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boost == active);
endmodule

bind fastlock_ctl fl_chk #(.TIMER_W(TIMER_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_word(ld_word),
  .wr_timer(wr_timer_w), .cnt(cnt_w), .active(active_o), .boost(boost_o),
  .sw_close(sw_close_o), .done(done_o)
);

// File: tb/sim_fastlock_ctl.sv
module sim_fastlock_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_word = '0;
  logic        boost_o, sw_close_o, active_o, done_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  logic [3:0] exp_q[$];   // {active, boost, sw_close, done}

  logic [11:0] m_cnt = '0;
  logic [3:0]  m_sel = '0;
  logic        m_done = 1'b0;

  always #5 clk = ~clk;

  fastlock_ctl u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_word(ld_word),
    .boost_o(boost_o), .sw_close_o(sw_close_o), .active_o(active_o), .done_o(done_o)
  );

  // Reference model from the requirements: address [2:0], mode [20:19],
  // timer [18:7], select [30:27]; switch code 4'b1100.
  always @(posedge clk) begin
    logic open_w;
    if (!rst_n) begin
      m_cnt = '0; m_sel = '0; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      if (ld_en && ld_word[2:0] == 3'd4) begin
        m_cnt = (ld_word[20:19] == 2'b01) ? ld_word[18:7] : 12'd0;
      end else if (m_cnt != 0) begin
        if (m_cnt == 12'd1) m_done = 1'b1;
        m_cnt = m_cnt - 12'd1;
      end
      if (ld_en && ld_word[2:0] == 3'd0) m_sel = ld_word[30:27];
    end
    open_w = (m_cnt != 0);
    exp_q.push_back({open_w, open_w, open_w && (m_sel == 4'b1100), m_done});
  end

  task automatic cmp(input logic a, input logic e, input string req, input string what);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s/%s %s: got %b expected %b at %0t", req, cur_req, what, a, e, $time);
    end
  endtask

  // Monitor: compares one scoreboard item per cycle.
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      logic [3:0] e;
      e = exp_q.pop_front();
      cmp(active_o,   e[3], "R3", "active_o");
      cmp(boost_o,    e[2], "R4", "boost_o");
      cmp(sw_close_o, e[1], "R5", "sw_close_o");
      cmp(done_o,     e[0], "R6", "done_o");
    end
  end

  function automatic logic [31:0] mk_tmr(input logic [1:0] mode, input logic [11:0] tv);
    logic [31:0] w = '0;
    w[2:0] = 3'd4; w[18:7] = tv; w[20:19] = mode;
    return w;
  endfunction

  function automatic logic [31:0] mk_sel(input logic [3:0] s);
    logic [31:0] w = '0;
    w[30:27] = s;
    return w;
  endfunction

  task automatic put(input logic [31:0] w);
    @(negedge clk); ld_en = 1'b1; ld_word = w;
    @(negedge clk); ld_en = 1'b0; ld_word = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    cur_req = "R1";
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    cur_req = "R5"; put(mk_sel(4'b1100)); idle(2);
    cur_req = "R3"; put(mk_tmr(2'b01, 12'd1)); idle(4);
    put(mk_tmr(2'b01, 12'd5)); idle(8);
    put(mk_tmr(2'b01, 12'd520)); idle(525);
    cur_req = "R2";
    put(32'h0018_0283); put(32'h0018_0285); put(32'h6000_0007); idle(4);
    put(mk_tmr(2'b01, 12'd10)); idle(2); put(32'h0018_0283); idle(12);
    cur_req = "R7"; put(mk_tmr(2'b01, 12'd20)); idle(8);
    put(mk_tmr(2'b01, 12'd6)); idle(10);
    cur_req = "R8"; put(mk_tmr(2'b01, 12'd20)); idle(5);
    put(mk_tmr(2'b10, 12'd7)); idle(4);
    put(mk_tmr(2'b01, 12'd20)); idle(3);
    put(mk_tmr(2'b01, 12'd0)); idle(4);
    cur_req = "R9"; put(mk_tmr(2'b01, 12'd30)); idle(5);
    put(mk_sel(4'b0000)); idle(5); put(mk_sel(4'b1100)); idle(25);
    cur_req = "R5"; put(mk_sel(4'b0101)); put(mk_tmr(2'b01, 12'd8)); idle(12);
    put(mk_sel(4'b1100));
    cur_req = "R3"; put(mk_tmr(2'b01, 12'd4095)); idle(4100);
    cur_req = "R1";
    @(negedge clk); rst_n = 1'b0; put(mk_tmr(2'b01, 12'd9)); idle(3);
    idle(2);
    summary();
    $finish;
  end
endmodule